// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt sources around the FIFOs of a 16550-style UART and produces one interrupt request and a 4-bit code that names the most urgent pending source. The inputs are the live receive FIFO fill count, a 2-bit trigger-level select, four line error pulses, a receive time-out level from an external timer, the transmit FIFO empty flag, per-source enable bits and one FIFO enable bit per direction. Strobes mark reads of the identification field, reads of the line status register and writes to the transmit holding register. The block also produces a data-ready status bit.

The FIFOs, the shift registers, the baud-rate generator and the time-out timer are outside the block. The receive-data and time-out conditions are evaluated combinationally from the live count. The line-status condition, the transmit-empty condition and the data-ready bit are held in registers and change on the clock edge after the event that moves them.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is held and on release, `irq` is 0, `iir_id` is 4'b0001 and `data_ready` is 0.
- R2: The trigger select maps 2'b00, 2'b01, 2'b10 and 2'b11 to 1, 4, 8 and FIFO_DEPTH-2 (14 by default) characters. When `rx_fifo_en` and `ie_rx_data` are both 1 and `rx_count` is at or above the trigger, the receive-data source is active, with code 4'b0100, in the same cycle.
- R3: The receive-data source drops in the same cycle that `rx_count` falls below the trigger.
- R4: Any bit of `line_err` sets a sticky line-status flag from the next cycle, with code 4'b0110. A cycle with `lsr_rd` high and no error clears the flag from the next cycle. An error in the same cycle as `lsr_rd` keeps the flag set.
- R5: Priority runs from line status, to receive data, to receive time-out, to transmit empty. With no active source the code is 4'b0001. `irq` is 1 exactly when the code is not 4'b0001.
- R6: `data_ready` is 1 in the cycle after a cycle with a nonzero `rx_count` and 0 in the cycle after a cycle with a zero count.
- R7: With the receive FIFO and its enable on, `rx_timeout` high and `rx_count` nonzero give code 4'b1100, unless a higher source is active. A zero count suppresses the time-out.
- R8: A transmit-empty pending flag sets on the clock edge that samples `tx_empty` high after a cycle in which it was low. After reset the previous value counts as low. With `tx_fifo_en` and `ie_tx_empty` set, the pending flag gives code 4'b0010. The flag also clears when `tx_empty` goes low.
- R9: `thr_wr` clears the transmit-empty pending flag from the next cycle. `iir_rd` clears it only when the code shown in that cycle is 4'b0010. Once cleared, the flag stays clear while `tx_empty` stays high, until `tx_empty` falls and rises again.
- R10: A source with its enable bit at 0 does not contribute to `irq` or `iir_id`. Its line-status and transmit-empty state is kept, and shows up as soon as the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| tx_fifo_en | input | 1 | Transmit FIFO enabled |
| ie_rx_data | input | 1 | Enable for receive data and time-out |
| ie_line | input | 1 | Enable for line status |
| ie_tx_empty | input | 1 | Enable for transmit empty |
| rx_count | input | CNT_W (5) | Receive FIFO fill count |
| trig_sel | input | 2 | Trigger level select |
| line_err | input | 4 | Error pulses: overrun, parity, framing, break |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_timeout | input | 1 | Time-out condition from external timer |
| tx_empty | input | 1 | Transmit FIFO empty |
| iir_rd | input | 1 | Identification field read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| iir_id | output | 4 | Identification code |
| data_ready | output | 1 | Receive FIFO holds data |

## Verification
The hardest state to reach is a transmit-empty flag that an identification read has cleared while the FIFO is still empty. It must stay clear until the FIFO fills and drains again, and it must not be cleared by a read that happened while a higher source was being shown. Directed steps clear the flag by a read, hold `tx_empty` high, then toggle it to re-arm the flag. A long random phase then mixes `iir_rd` pulses with line errors and counts above the trigger, so that reads land while other codes are shown. An error in the same cycle as a status read is also driven on purpose.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_NONE    = 4'b0001,
        IID_LINE    = 4'b0110,
        IID_RXDATA  = 4'b0100,
        IID_TIMEOUT = 4'b1100,
        IID_TXEMPTY = 4'b0010
    } iid_e;

    // Trigger threshold in characters for a 2-bit select.
    function automatic int trig_chars(input logic [1:0] sel, input int depth);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uirq_rx_level.sv
module uirq_rx_level #(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             fifo_en,
    input  logic             ie,
    input  logic             rx_timeout,
    output logic [CNT_W-1:0] trig,
    output logic             data_hit,
    output logic             tmo_hit,
    output logic             dr
);
    import uart_irq_pkg::*;

    typedef struct packed {
        logic dr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        trig     = CNT_W'(trig_chars(trig_sel, DEPTH));
        data_hit = fifo_en && ie && (rx_count >= trig);
        tmo_hit  = fifo_en && ie && rx_timeout && (rx_count != '0);
        st_d     = st_q;
        st_d.dr  = (rx_count != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dr = st_q.dr;

    // R6: status reflects the previous cycle's occupancy
    a_r6_dr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !dr);

endmodule

// File: rtl/uirq_line_latch.sv
module uirq_line_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] line_err,
    input  logic       lsr_rd,
    output logic       ls_pend
);
    typedef struct packed {
        logic pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (|line_err) || (st_q.pend && !lsr_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ls_pend = st_q.pend;

    a_r4_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_err) |=> ls_pend);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !(|line_err)) |=> !ls_pend);

endmodule

// File: rtl/uirq_thre_track.sv
module uirq_thre_track (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic thr_wr,
    input  logic id_rd_clr,
    output logic thre_pend
);
    typedef struct packed {
        logic pend;
        logic prev;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        rise      = tx_empty && !st_q.prev;
        st_d      = st_q;
        st_d.prev = tx_empty;
        st_d.pend = ((st_q.pend && tx_empty) || rise) && !(thr_wr || id_rd_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thre_pend = st_q.pend;

    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre_pend);

    a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !st_q.prev && !thr_wr && !id_rd_clr) |=> thre_pend);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
    parameter  int FIFO_DEPTH = 16,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_fifo_en,
    input  logic             tx_fifo_en,
    input  logic             ie_rx_data,
    input  logic             ie_line,
    input  logic             ie_tx_empty,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic [3:0]       line_err,
    input  logic             lsr_rd,
    input  logic             rx_timeout,
    input  logic             tx_empty,
    input  logic             iir_rd,
    input  logic             thr_wr,
    output logic             irq,
    output logic [3:0]       iir_id,
    output logic             data_ready
);
    import uart_irq_pkg::*;

    logic [CNT_W-1:0] trig;
    logic             data_hit, tmo_hit, ls_pend, thre_pend, id_rd_clr;
    iid_e             id_c;

    uirq_rx_level #(.DEPTH(FIFO_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .trig_sel(trig_sel),
        .fifo_en(rx_fifo_en), .ie(ie_rx_data), .rx_timeout(rx_timeout),
        .trig(trig), .data_hit(data_hit), .tmo_hit(tmo_hit), .dr(data_ready)
    );

    uirq_line_latch u_line (
        .clk(clk), .rst_n(rst_n), .line_err(line_err), .lsr_rd(lsr_rd),
        .ls_pend(ls_pend)
    );

    uirq_thre_track u_thre (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .thr_wr(thr_wr),
        .id_rd_clr(id_rd_clr), .thre_pend(thre_pend)
    );

    // Fixed priority selection of the identification code.
    always_comb begin
        if (ls_pend && ie_line)                          id_c = IID_LINE;
        else if (data_hit)                               id_c = IID_RXDATA;
        else if (tmo_hit)                                id_c = IID_TIMEOUT;
        else if (thre_pend && tx_fifo_en && ie_tx_empty) id_c = IID_TXEMPTY;
        else                                             id_c = IID_NONE;
    end

    assign id_rd_clr = iir_rd && (id_c == IID_TXEMPTY);
    assign iir_id    = id_c;
    assign irq       = (id_c != IID_NONE);

    a_r5_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_pend && ie_line) |-> (iir_id == IID_LINE));

    a_r3_below_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count < trig) |-> (iir_id != IID_RXDATA));

    a_r10_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_tx_empty |-> (iir_id != IID_TXEMPTY));

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 0;
    logic          rst_n = 0;
    logic          rx_fifo_en = 0, tx_fifo_en = 0;
    logic          ie_rx_data = 0, ie_line = 0, ie_tx_empty = 0;
    logic [CW-1:0] rx_count = 0;
    logic [1:0]    trig_sel = 0;
    logic [3:0]    line_err = 0;
    logic          lsr_rd = 0, rx_timeout = 0, tx_empty = 0, iir_rd = 0, thr_wr = 0;
    logic          irq, data_ready;
    logic [3:0]    iir_id;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state
    bit m_ls = 0, m_thre = 0, m_prev = 0, m_dr = 0;

    always #2 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(DEPTH)) i_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .rx_fifo_en(rx_fifo_en), .tx_fifo_en(tx_fifo_en),
        .ie_rx_data(ie_rx_data), .ie_line(ie_line), .ie_tx_empty(ie_tx_empty),
        .rx_count(rx_count), .trig_sel(trig_sel), .line_err(line_err),
        .lsr_rd(lsr_rd), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
        .iir_rd(iir_rd), .thr_wr(thr_wr), .irq(irq), .iir_id(iir_id),
        .data_ready(data_ready)
    );

    function automatic int exp_trig();
        case (trig_sel)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return DEPTH - 2;
        endcase
    endfunction

    function automatic logic [3:0] exp_id();
        if (m_ls && ie_line) return 4'b0110;
        if (rx_fifo_en && ie_rx_data && int'(rx_count) >= exp_trig()) return 4'b0100;
        if (rx_fifo_en && ie_rx_data && rx_timeout && rx_count != 0) return 4'b1100;
        if (m_thre && tx_fifo_en && ie_tx_empty) return 4'b0010;
        return 4'b0001;
    endfunction

    function automatic string id_tag(input logic [3:0] c);
        case (c)
            4'b0110: return "R4";
            4'b0100: return "R2";
            4'b1100: return "R7";
            4'b0010: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the reference, away from the edge.
    task automatic settle();
        logic [3:0] e;
        #1;
        e = exp_id();
        chk(id_tag(e), iir_id, e);
        chk("R5", {3'b0, irq}, {3'b0, e != 4'b0001});
        chk("R6", {3'b0, data_ready}, {3'b0, m_dr});
    endtask

    // Advance one clock and update the reference.
    task automatic adv();
        logic [3:0] e;
        bit clr;
        e = exp_id();
        @(posedge clk);
        clr    = thr_wr || (iir_rd && e == 4'b0010);
        m_thre = ((m_thre && tx_empty) || (tx_empty && !m_prev)) && !clr;
        m_prev = tx_empty;
        m_ls   = (|line_err) || (m_ls && !lsr_rd);
        m_dr   = (rx_count != 0);
        @(negedge clk);
    endtask

    task automatic step();
        settle();
        adv();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        // R1: state under reset
        chk("R1", iir_id, 4'b0001);
        chk("R1", {3'b0, irq}, 4'b0);
        chk("R1", {3'b0, data_ready}, 4'b0);
        @(negedge clk);
        rst_n = 1;
        step();
        settle();
        chk("R1", iir_id, 4'b0001);
        adv();

        // R2: threshold 4
        rx_fifo_en = 1; ie_rx_data = 1; trig_sel = 2'b01; rx_count = 4;
        settle(); chk("R2", iir_id, 4'b0100); adv();
        rx_count = 3;
        settle(); chk("R3", iir_id, 4'b0001); adv();
        trig_sel = 2'b00; rx_count = 1;
        settle(); chk("R2", iir_id, 4'b0100); adv();
        trig_sel = 2'b11; rx_count = 13;
        settle(); chk("R3", iir_id, 4'b0001); adv();
        rx_count = 14;
        settle(); chk("R2", iir_id, 4'b0100); adv();
        trig_sel = 2'b01; rx_count = 3;

        // R7: time-out below trigger, suppressed when empty
        rx_timeout = 1;
        settle(); chk("R7", iir_id, 4'b1100); adv();
        rx_count = 0;
        settle(); chk("R7", iir_id, 4'b0001); adv();
        rx_timeout = 0; rx_count = 4;

        // R4/R5: line status over receive data; error with simultaneous read
        line_err = 4'b0001; ie_line = 1; step();
        line_err = 0;
        settle(); chk("R5", iir_id, 4'b0110); adv();
        lsr_rd = 1; line_err = 4'b0100; step();
        lsr_rd = 0; line_err = 0;
        settle(); chk("R4", iir_id, 4'b0110); adv();
        lsr_rd = 1; step();
        lsr_rd = 0;
        settle(); chk("R4", iir_id, 4'b0100); adv();

        // R8/R9: transmit empty tracking
        rx_count = 0; tx_fifo_en = 1; ie_tx_empty = 1; tx_empty = 1;
        settle(); chk("R8", iir_id, 4'b0001); adv();
        settle(); chk("R8", iir_id, 4'b0010); adv();
        iir_rd = 1; step();
        iir_rd = 0;
        settle(); chk("R9", iir_id, 4'b0001); adv();
        step(); step();
        settle(); chk("R9", iir_id, 4'b0001); adv();
        tx_empty = 0; step();
        tx_empty = 1; step();
        settle(); chk("R9", iir_id, 4'b0010); adv();
        thr_wr = 1; step();
        thr_wr = 0;
        settle(); chk("R9", iir_id, 4'b0001); adv();

        // R10: disabled source keeps its state
        ie_line = 0; line_err = 4'b1000; step();
        line_err = 0;
        settle(); chk("R10", iir_id, 4'b0001); adv();
        ie_line = 1;
        settle(); chk("R10", iir_id, 4'b0110); adv();
        lsr_rd = 1; step();
        lsr_rd = 0;

        // Mixed random traffic against the reference
        for (int i = 0; i < 6000; i++) begin
            rx_count   = CW'($urandom % (DEPTH + 1));
            if ($urandom % 8 == 0) trig_sel = 2'($urandom);
            if ($urandom % 16 == 0) rx_fifo_en  = ~rx_fifo_en;
            if ($urandom % 16 == 0) tx_fifo_en  = ~tx_fifo_en;
            if ($urandom % 16 == 0) ie_rx_data  = ~ie_rx_data;
            if ($urandom % 16 == 0) ie_line     = ~ie_line;
            if ($urandom % 16 == 0) ie_tx_empty = ~ie_tx_empty;
            line_err   = ($urandom % 12 == 0) ? 4'($urandom) : 4'b0;
            lsr_rd     = ($urandom % 6 == 0);
            rx_timeout = ($urandom % 4 == 0);
            iir_rd     = ($urandom % 5 == 0);
            thr_wr     = ($urandom % 9 == 0);
            if ($urandom % 5 == 0) tx_empty = ~tx_empty;
            step();
        end
        finish_run();
    end

endmodule